// File: doc/BRIEF.md
# Intersection Light Controller with Demand Sensing

This block sequences the lamps of a two-way crossing: a main road that rests on green and a side street that gets green only when a vehicle has asked for it. Every phase length is counted in ticks of a one-per-second enable. The clock may run far faster, and nothing advances between ticks. Each road has its own crosswalk countdown. The value is a binary output that a separate seven-segment decoder can show.

Two stop-line sensors watch the side-street approaches. When a vehicle crosses a stop line while the side street is red, the camera for that line gets a single clock-wide trigger. All lamp and camera outputs are plain on/off levels. Display decoding and the one-second timebase sit outside this block.

Top module: `tl_intersection_ctrl`

## Requirements
- R1: The two green lamps are never on together, and each road shows exactly one of green, yellow or red at all times.
- R2: After leaving main green, the phases run main yellow for 3 ticks, all-red for 1 tick, side green for 8 ticks, side yellow for 3 ticks and all-red for 1 tick, then main green again.
- R3: Main green lasts at least 10 ticks. Without a pending request it holds for any number of ticks. With a request pending at its 10th or any later tick, it moves to main yellow on that tick.
- R4: A high level on either side-approach input for a single clock latches a side-street request. The request clears on the clock edge at which side green begins, and clearing wins over a sensor high on that same edge. A request raised during side green is kept for the next cycle.
- R5: Each crosswalk count loads 9 on the clock edge at which its road turns green. It decreases by one on each tick while that road stays green and stops at 0. It reads 0 from the edge at which the road leaves green.
- R6: A stop-line input that goes from low to high while the side street is red makes its own camera output high for exactly one clock. The pulse appears in the cycle after the sensor is first seen high. A sensor held high does not fire again until it has gone low and high again.
- R7: No camera pulse is produced for a rising edge of a stop-line input that occurs while the side street is not red.
- R8: After reset is released, the main road is green, the side street is red, both counts are 0, no request is pending and both cameras are low.
- R9: In clocks where the tick input is low, no lamp changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable, once per second |
| side_appr_n_i | input | 1 | North side-street approach sensor (request) |
| side_appr_s_i | input | 1 | South side-street approach sensor (request) |
| stop_n_i | input | 1 | North stop-line sensor, drives cam_n_o |
| stop_s_i | input | 1 | South stop-line sensor, drives cam_s_o |
| main_grn_o | output | 1 | Main road green lamp |
| main_yel_o | output | 1 | Main road yellow lamp |
| main_red_o | output | 1 | Main road red lamp |
| side_grn_o | output | 1 | Side street green lamp |
| side_yel_o | output | 1 | Side street yellow lamp |
| side_red_o | output | 1 | Side street red lamp |
| main_walk_o | output | 4 | Main road crosswalk count |
| side_walk_o | output | 4 | Side street crosswalk count |
| cam_n_o | output | 1 | North stop-line camera trigger |
| cam_s_o | output | 1 | South stop-line camera trigger |

## Verification
The bench targets the edges of the minimum main green. A request held from the start of main green must leave on the tenth tick and not earlier. A design that counted from zero or one too far would switch a tick early or late. A design that dropped the saturated count would need a fresh minimum after a late request.

The bench also checks that a request is consumed when side green starts. If it were not consumed, the main road would cycle without any demand. The countdown is checked for the value at its load, its stop at zero and its clear on leaving green. A design that followed the lamp one clock late would show a stale count for one cycle.

On the cameras, the bench holds a sensor high to look for a repeated trigger. It also raises a sensor during side green and keeps it high into red. An edge detector gated at the wrong moment would fire in that case.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [2:0] {
    PH_MAIN_GO       = 3'd0,
    PH_MAIN_WARN     = 3'd1,
    PH_CLEAR_TO_SIDE = 3'd2,
    PH_SIDE_GO       = 3'd3,
    PH_SIDE_WARN     = 3'd4,
    PH_CLEAR_TO_MAIN = 3'd5
  } phase_e;

  typedef struct packed {
    logic grn;
    logic yel;
    logic red;
  } lamp_t;

  localparam int unsigned NUM_ROADS = 2;
  localparam int unsigned ROAD_MAIN = 0;
  localparam int unsigned ROAD_SIDE = 1;

endpackage

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
  import tl_pkg::*;
#(
  parameter int unsigned MAIN_GO_MIN = 10,
  parameter int unsigned MAIN_WARN   = 3,
  parameter int unsigned CLEAR       = 1,
  parameter int unsigned SIDE_GO     = 8,
  parameter int unsigned SIDE_WARN   = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   demand_i,
  output phase_e phase_o,
  output phase_e phase_nxt_o
);

  localparam int unsigned MAX_GO   = (MAIN_GO_MIN > SIDE_GO) ? MAIN_GO_MIN : SIDE_GO;
  localparam int unsigned MAX_WARN = (MAIN_WARN > SIDE_WARN) ? MAIN_WARN : SIDE_WARN;
  localparam int unsigned MAX_GW   = (MAX_GO > MAX_WARN) ? MAX_GO : MAX_WARN;
  localparam int unsigned MAX_DUR  = (MAX_GW > CLEAR) ? MAX_GW : CLEAR;
  localparam int unsigned CNT_W    = (MAX_DUR > 2) ? $clog2(MAX_DUR) : 1;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               at_last;

  function automatic logic [CNT_W-1:0] last_of(phase_e p);
    case (p)
      PH_MAIN_GO:   return CNT_W'(MAIN_GO_MIN - 1);
      PH_MAIN_WARN: return CNT_W'(MAIN_WARN - 1);
      PH_SIDE_GO:   return CNT_W'(SIDE_GO - 1);
      PH_SIDE_WARN: return CNT_W'(SIDE_WARN - 1);
      default:      return CNT_W'(CLEAR - 1);
    endcase
  endfunction

  function automatic phase_e succ_of(phase_e p);
    case (p)
      PH_MAIN_GO:       return PH_MAIN_WARN;
      PH_MAIN_WARN:     return PH_CLEAR_TO_SIDE;
      PH_CLEAR_TO_SIDE: return PH_SIDE_GO;
      PH_SIDE_GO:       return PH_SIDE_WARN;
      PH_SIDE_WARN:     return PH_CLEAR_TO_MAIN;
      default:          return PH_MAIN_GO;
    endcase
  endfunction

  assign at_last = (cnt_q == last_of(phase_q));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (tick_i) begin
      if (at_last) begin
        // main green saturates at its minimum until demand shows up
        if (phase_q != PH_MAIN_GO || demand_i) begin
          phase_d = succ_of(phase_q);
          cnt_d   = '0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_MAIN_GO;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_d;

endmodule

// File: rtl/tl_demand_latch.sv
module tl_demand_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;

  // clear wins over a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/tl_walk_timer.sv
module tl_walk_timer #(
  parameter int unsigned LOAD = 9,
  parameter int unsigned W    = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         green_i,
  input  logic         green_nxt_i,
  output logic [W-1:0] val_o
);

  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       val_q <= '0;
    else if (!green_nxt_i)             val_q <= '0;
    else if (!green_i)                 val_q <= W'(LOAD);
    else if (tick_i && val_q != '0)    val_q <= val_q - 1'b1;
  end

  assign val_o = val_q;

endmodule

// File: rtl/tl_stop_cam.sv
module tl_stop_cam (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sens_i,
  input  logic armed_i,
  output logic fire_o
);

  logic prev_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      prev_q <= sens_i;
      fire_q <= sens_i & ~prev_q & armed_i;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/tl_intersection_ctrl.sv
module tl_intersection_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned MAIN_GO_MIN = 10,
  parameter int unsigned MAIN_WARN   = 3,
  parameter int unsigned CLEAR       = 1,
  parameter int unsigned SIDE_GO     = 8,
  parameter int unsigned SIDE_WARN   = 3,
  parameter int unsigned WALK_LOAD   = 9,
  localparam int unsigned WALK_W     = $clog2(WALK_LOAD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              side_appr_n_i,
  input  logic              side_appr_s_i,
  input  logic              stop_n_i,
  input  logic              stop_s_i,
  output logic              main_grn_o,
  output logic              main_yel_o,
  output logic              main_red_o,
  output logic              side_grn_o,
  output logic              side_yel_o,
  output logic              side_red_o,
  output logic [WALK_W-1:0] main_walk_o,
  output logic [WALK_W-1:0] side_walk_o,
  output logic              cam_n_o,
  output logic              cam_s_o
);

  phase_e phase_q, phase_nxt;
  logic   pend_q;
  logic   enter_side;
  lamp_t  main_lamp, side_lamp;

  logic [NUM_ROADS-1:0] grn_now, grn_nxt;
  logic [WALK_W-1:0]    walk [NUM_ROADS];
  logic [1:0]           stop_vec, cam_vec;

  tl_phase_seq #(
    .MAIN_GO_MIN (MAIN_GO_MIN),
    .MAIN_WARN   (MAIN_WARN),
    .CLEAR       (CLEAR),
    .SIDE_GO     (SIDE_GO),
    .SIDE_WARN   (SIDE_WARN)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .demand_i    (pend_q),
    .phase_o     (phase_q),
    .phase_nxt_o (phase_nxt)
  );

  assign enter_side = (phase_nxt == PH_SIDE_GO) && (phase_q != PH_SIDE_GO);

  tl_demand_latch u_demand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (side_appr_n_i | side_appr_s_i),
    .clr_i  (enter_side),
    .pend_o (pend_q)
  );

  always_comb begin
    main_lamp = '{grn: 1'b0, yel: 1'b0, red: 1'b1};
    side_lamp = '{grn: 1'b0, yel: 1'b0, red: 1'b1};
    case (phase_q)
      PH_MAIN_GO:   main_lamp = '{grn: 1'b1, yel: 1'b0, red: 1'b0};
      PH_MAIN_WARN: main_lamp = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
      PH_SIDE_GO:   side_lamp = '{grn: 1'b1, yel: 1'b0, red: 1'b0};
      PH_SIDE_WARN: side_lamp = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
      default: ;
    endcase
  end

  assign {main_grn_o, main_yel_o, main_red_o} = main_lamp;
  assign {side_grn_o, side_yel_o, side_red_o} = side_lamp;

  assign grn_now[ROAD_MAIN] = (phase_q   == PH_MAIN_GO);
  assign grn_now[ROAD_SIDE] = (phase_q   == PH_SIDE_GO);
  assign grn_nxt[ROAD_MAIN] = (phase_nxt == PH_MAIN_GO);
  assign grn_nxt[ROAD_SIDE] = (phase_nxt == PH_SIDE_GO);

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_walk
    tl_walk_timer #(
      .LOAD (WALK_LOAD),
      .W    (WALK_W)
    ) u_walk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .green_i     (grn_now[r]),
      .green_nxt_i (grn_nxt[r]),
      .val_o       (walk[r])
    );
  end

  assign main_walk_o = walk[ROAD_MAIN];
  assign side_walk_o = walk[ROAD_SIDE];

  assign stop_vec = {stop_s_i, stop_n_i};

  for (genvar c = 0; c < 2; c++) begin : g_cam
    tl_stop_cam u_cam (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sens_i  (stop_vec[c]),
      .armed_i (side_lamp.red),
      .fire_o  (cam_vec[c])
    );
  end

  assign cam_n_o = cam_vec[0];
  assign cam_s_o = cam_vec[1];

endmodule

// File: rtl/tl_intersection_ctrl_chk.sv
module tl_intersection_ctrl_chk #(
  parameter int unsigned WALK_LOAD = 9,
  parameter int unsigned WALK_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              main_grn_i,
  input logic              main_yel_i,
  input logic              main_red_i,
  input logic              side_grn_i,
  input logic              side_yel_i,
  input logic              side_red_i,
  input logic [WALK_W-1:0] main_walk_i,
  input logic [WALK_W-1:0] side_walk_i,
  input logic              cam_n_i,
  input logic              cam_s_i,
  input logic              pend_i
);

  p_no_dual_green_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_grn_i && side_grn_i));

  p_one_lamp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({main_grn_i, main_yel_i, main_red_i}) && $onehot({side_grn_i, side_yel_i, side_red_i}));

  p_warn_after_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(side_yel_i) |-> $past(side_grn_i));

  p_side_go_needs_demand_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(side_grn_i) |-> $past(pend_i));

  p_demand_consumed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(side_grn_i) |-> !pend_i);

  p_walk_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(side_grn_i) |-> side_walk_i == WALK_W'(WALK_LOAD));

  p_walk_off_main_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_grn_i |-> main_walk_i == '0);

  p_walk_off_side_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !side_grn_i |-> side_walk_i == '0);

  p_walk_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_grn_i && $past(side_grn_i) && $past(tick_i) && $past(side_walk_i) != '0)
      |-> side_walk_i == $past(side_walk_i) - WALK_W'(1));

  p_cam_n_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cam_n_i |=> !cam_n_i);

  p_cam_s_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cam_s_i |=> !cam_s_i);

  p_cam_red_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cam_n_i || cam_s_i) |-> $past(side_red_i));

  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable({main_grn_i, main_yel_i, main_red_i, side_grn_i, side_yel_i, side_red_i}));

endmodule

bind tl_intersection_ctrl tl_intersection_ctrl_chk #(
  .WALK_LOAD (WALK_LOAD),
  .WALK_W    (WALK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .main_grn_i  (main_grn_o),
  .main_yel_i  (main_yel_o),
  .main_red_i  (main_red_o),
  .side_grn_i  (side_grn_o),
  .side_yel_i  (side_yel_o),
  .side_red_i  (side_red_o),
  .main_walk_i (main_walk_o),
  .side_walk_i (side_walk_o),
  .cam_n_i     (cam_n_o),
  .cam_s_i     (cam_s_o),
  .pend_i      (pend_q)
);

// File: tb/tl_intersection_ctrl_bench.sv
`timescale 1ns/1ps
module tl_intersection_ctrl_bench;

  localparam int SEL_MAIN = 0;
  localparam int SEL_SIDE = 1;
  localparam int SEL_MWLK = 2;
  localparam int SEL_SWLK = 3;
  localparam int SEL_CAM  = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       appr_n = 1'b0, appr_s = 1'b0, stop_n = 1'b0, stop_s = 1'b0;
  logic       main_grn, main_yel, main_red, side_grn, side_yel, side_red;
  logic [3:0] main_walk, side_walk;
  logic       cam_n, cam_s;

  typedef struct {
    int    cyc;
    int    sel;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc_cnt = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  tl_intersection_ctrl u_tl_intersection_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .side_appr_n_i (appr_n),
    .side_appr_s_i (appr_s),
    .stop_n_i      (stop_n),
    .stop_s_i      (stop_s),
    .main_grn_o    (main_grn),
    .main_yel_o    (main_yel),
    .main_red_o    (main_red),
    .side_grn_o    (side_grn),
    .side_yel_o    (side_yel),
    .side_red_o    (side_red),
    .main_walk_o   (main_walk),
    .side_walk_o   (side_walk),
    .cam_n_o       (cam_n),
    .cam_s_o       (cam_s)
  );

  function automatic int act_of(int sel);
    case (sel)
      SEL_MAIN: return int'({main_grn, main_yel, main_red});
      SEL_SIDE: return int'({side_grn, side_yel, side_red});
      SEL_MWLK: return int'(main_walk);
      SEL_SWLK: return int'(side_walk);
      default:  return int'({cam_n, cam_s});
    endcase
  endfunction

  // monitor: compare due items half a cycle after the edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
      item_t it;
      int    act;
      it  = q.pop_front();
      act = act_of(it.sel);
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d at cycle %0d", it.tag, it.sel, act, it.exp, cyc_cnt);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      step();
      tick_i = 1'b0;
    end
  endtask

  task automatic expect_now(int sel, int exp, string tag);
    item_t it;
    it = '{cyc: cyc_cnt, sel: sel, exp: exp, tag: tag};
    q.push_back(it);
  endtask

  // lamp codes {grn,yel,red}: 4 green, 2 yellow, 1 red
  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    expect_now(SEL_MAIN, 4, "R8");
    expect_now(SEL_SIDE, 1, "R8");
    expect_now(SEL_MWLK, 0, "R8");
    expect_now(SEL_SWLK, 0, "R8");
    expect_now(SEL_CAM,  0, "R8");

    ticks(25);
    expect_now(SEL_MAIN, 4, "R3");
    expect_now(SEL_SIDE, 1, "R3");

    appr_n = 1'b1; step(); appr_n = 1'b0;
    repeat (4) step();
    expect_now(SEL_MAIN, 4, "R9");
    ticks(1);
    expect_now(SEL_MAIN, 2, "R4");

    ticks(2);
    expect_now(SEL_MAIN, 2, "R2");
    ticks(1);
    expect_now(SEL_MAIN, 1, "R2");
    expect_now(SEL_SIDE, 1, "R2");
    ticks(1);
    expect_now(SEL_SIDE, 4, "R2");
    expect_now(SEL_MAIN, 1, "R1");
    expect_now(SEL_SWLK, 9, "R5");

    ticks(7);
    expect_now(SEL_SIDE, 4, "R2");
    expect_now(SEL_SWLK, 2, "R5");
    ticks(1);
    expect_now(SEL_SIDE, 2, "R2");
    expect_now(SEL_SWLK, 0, "R5");
    ticks(2);
    expect_now(SEL_SIDE, 2, "R2");
    ticks(1);
    expect_now(SEL_SIDE, 1, "R2");
    expect_now(SEL_MAIN, 1, "R2");
    ticks(1);
    expect_now(SEL_MAIN, 4, "R2");
    expect_now(SEL_MWLK, 9, "R5");

    ticks(8);
    expect_now(SEL_MWLK, 1, "R5");
    ticks(1);
    expect_now(SEL_MWLK, 0, "R5");
    ticks(3);
    expect_now(SEL_MWLK, 0, "R5");
    ticks(20);
    expect_now(SEL_MAIN, 4, "R4");

    // south approach request; minimum already served
    appr_s = 1'b1; step(); appr_s = 1'b0;
    ticks(1);
    expect_now(SEL_MAIN, 2, "R4");
    ticks(3);
    ticks(1);
    expect_now(SEL_SIDE, 4, "R2");
    appr_n = 1'b1; step(); appr_n = 1'b0;
    ticks(8);
    ticks(3);
    ticks(1);
    expect_now(SEL_MAIN, 4, "R2");
    ticks(9);
    expect_now(SEL_MAIN, 4, "R3");
    expect_now(SEL_MWLK, 0, "R5");
    ticks(1);
    expect_now(SEL_MAIN, 2, "R3");

    // cameras while side street red; cam code {n,s}
    stop_n = 1'b1; step();
    expect_now(SEL_CAM, 2, "R6");
    step();
    expect_now(SEL_CAM, 0, "R6");
    step();
    expect_now(SEL_CAM, 0, "R6");
    stop_n = 1'b0; step();
    stop_n = 1'b1; step();
    expect_now(SEL_CAM, 2, "R6");
    stop_n = 1'b0; step();
    stop_n = 1'b1; stop_s = 1'b1; step();
    expect_now(SEL_CAM, 3, "R6");
    stop_n = 1'b0; stop_s = 1'b0; step();

    ticks(3);
    ticks(1);
    expect_now(SEL_SIDE, 4, "R2");
    stop_s = 1'b1; step();
    expect_now(SEL_CAM, 0, "R7");
    step();
    expect_now(SEL_CAM, 0, "R7");
    ticks(8);
    ticks(3);
    expect_now(SEL_SIDE, 1, "R2");
    step();
    expect_now(SEL_CAM, 0, "R7");
    stop_s = 1'b0; step();
    stop_s = 1'b1; step();
    expect_now(SEL_CAM, 1, "R6");
    stop_s = 1'b0;

    repeat (3) step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule